// File: doc/BRIEF.md
# AC-Link Controller Frame Engine

This block is the controller end of an AC97-style serial audio link. It runs entirely from the bit clock that the codec supplies. Every 256 bit-clock cycles it emits one outgoing frame on a serial data line: a 16-bit tag slot followed by twelve 20-bit data slots, sent most significant bit first. A frame-marker output (SYNC) rises once per frame, one cycle ahead of the first tag bit, and stays high for sixteen cycles. Serial outputs change on the rising bit-clock edge. The serial input from the codec is sampled on the falling edge.

On the send side, a parallel stereo playback pair (18-bit left and right) and a raw command pair (address and data words for data slots 1 and 2) are each offered with a one-cycle valid strobe. The most recent offer is held until the next frame boundary and then goes out in exactly one frame, together with the matching tag flags. On the receive side the block deserializes the codec's frame. It presents the received tag, the raw status words from data slots 1 and 2, and the stereo record pair from data slots 3 and 4, each with a one-cycle valid strobe that depends on the received tag flags.

Top module: `aclink_frame_engine`

## Requirements
- R1: SYNC rises exactly once every 256 bit-clock cycles, and never earlier than 256 cycles after its previous rise.
- R2: SYNC is high for exactly 16 consecutive cycles per frame. It rises one cycle before tag bit 15 (the first bit of the frame) appears on `sdata_out`.
- R3: The frame is sent MSB first. Tag bits 15..0 come first, then data slots 1..12 of 20 bits each. The flag for data slot s sits at tag bit 15-s. Tag bit 15 (frame valid) is set when any slot flag is set, and the whole tag is zero otherwise.
- R4: When a playback pair was strobed in since the previous frame boundary, data slot 3 carries {left, 2'b00} and data slot 4 carries {right, 2'b00}, with tag bits 12 and 11 set. When no pair was strobed, both slots are all zero and both flags are clear. A pair is sent in one frame only.
- R5: When several playback strobes arrive before one frame boundary, only the last pair is sent.
- R6: A strobed command pair is sent raw in data slot 1 (`cmd_addr`) and data slot 2 (`cmd_data`) of the next frame, with tag bits 14 and 13 set. With no command, both slots are zero.
- R7: Data slots 5 to 12 of the outgoing frame are always zero.
- R8: `sdata_in` is sampled on the falling bit-clock edge, with bit positions aligned to the outgoing frame. `rec_tag` holds the received 16-bit tag from bit position 16 onward.
- R9: `rec_valid` is a one-cycle pulse in bit position 96 of a frame whose received tag has bits 15, 12 and 11 all set. It then presents `rec_left` = received slot 3 bits 19:2 and `rec_right` = received slot 4 bits 19:2. In any other frame it stays low.
- R10: `stat_valid` is a one-cycle pulse in bit position 56 of a frame whose received tag has bits 15 and 14 set. It then presents the raw received slots 1 and 2 on `stat_addr` and `stat_data`.
- R11: While reset is low, `sync`, `sdata_out`, `rec_valid` and `stat_valid` are low. SYNC rises on the first rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock from the codec |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | output | 1 | Frame marker, rising edge starts a frame |
| sdata_out | output | 1 | Serial frame to the codec, driven on rising edge |
| sdata_in | input | 1 | Serial frame from the codec, sampled on falling edge |
| play_valid | input | 1 | Strobe: playback pair present |
| play_left | input | 18 | Left playback sample |
| play_right | input | 18 | Right playback sample |
| cmd_valid | input | 1 | Strobe: command pair present |
| cmd_addr | input | 20 | Raw word for outgoing data slot 1 |
| cmd_data | input | 20 | Raw word for outgoing data slot 2 |
| rec_valid | output | 1 | Strobe: record pair present |
| rec_left | output | 18 | Left record sample |
| rec_right | output | 18 | Right record sample |
| rec_tag | output | 16 | Tag of the received frame |
| stat_valid | output | 1 | Strobe: status pair present |
| stat_addr | output | 20 | Raw received data slot 1 |
| stat_data | output | 20 | Raw received data slot 2 |

## Verification
A strobed playback or command pair takes effect in the frame that starts after the next SYNC rise, never the current one. The bench therefore strobes just after a SYNC rise and inspects the following frame. Bit position p of a frame is taken at the falling edge p+1 cycles after the falling edge at which SYNC is first seen high. At that point `sdata_out` holds bit p and the bench's own `sdata_in` bit p is stable. Received results come one edge after the last bit of their slot: `rec_tag` from position 16, `stat_valid` in position 56 and `rec_valid` in position 96. The bench records the position at which each strobe is seen and compares it with these values.

// File: rtl/aclink_pkg.sv
// Package: aclink_pkg
// Shared frame geometry for the AC-link controller frame engine.
// Assumes a frame length that is a power of two, so that the bit
// position counter wraps naturally.
package aclink_pkg;
    localparam int FRAME_BITS   = 256;
    localparam int TAG_BITS     = 16;
    localparam int SLOT_BITS    = 20;
    localparam int NUM_SLOTS    = 12;
    localparam int SAMPLE_BITS  = 18;
    localparam int POS_W        = $clog2(FRAME_BITS);
    localparam int SLOT_IDX_W   = $clog2(NUM_SLOTS + 1);
    localparam int OFF_W        = $clog2(SLOT_BITS);

    // slot numbers whose contents the engine handles
    localparam int SLOT_CMD_ADDR = 1;
    localparam int SLOT_CMD_DATA = 2;
    localparam int SLOT_PCM_L    = 3;
    localparam int SLOT_PCM_R    = 4;

    // tag bit positions (slot s is flagged at TAG_BITS-1-s)
    localparam int TAG_FRAME_OK  = TAG_BITS - 1;
    localparam int TAG_CMD_ADDR  = TAG_BITS - 1 - SLOT_CMD_ADDR;
    localparam int TAG_CMD_DATA  = TAG_BITS - 1 - SLOT_CMD_DATA;
    localparam int TAG_PCM_L     = TAG_BITS - 1 - SLOT_PCM_L;
    localparam int TAG_PCM_R     = TAG_BITS - 1 - SLOT_PCM_R;

    // first bit position of a data slot (1-based slot number)
    function automatic int slot_first_pos(input int s);
        return TAG_BITS + SLOT_BITS * (s - 1);
    endfunction
endpackage

// File: rtl/aclink_slot_decode.sv
// Module: aclink_slot_decode
// Maps a frame bit position to a slot number (0 = tag slot, 1..NUM_SLOTS
// = data slots) and the bit offset inside that slot, counted from the
// slot's first (most significant) bit. Purely combinational.
// Assumes TAG_W + NUM_SLOTS*SLOT_W equals the frame length.
module aclink_slot_decode #(
    parameter int POS_W      = aclink_pkg::POS_W,
    parameter int TAG_W      = aclink_pkg::TAG_BITS,
    parameter int SLOT_W     = aclink_pkg::SLOT_BITS,
    parameter int NUM_SLOTS  = aclink_pkg::NUM_SLOTS,
    parameter int SLOT_IDX_W = aclink_pkg::SLOT_IDX_W,
    parameter int OFF_W      = aclink_pkg::OFF_W
) (
    input  logic [POS_W-1:0]      pos,
    output logic [SLOT_IDX_W-1:0] slot,
    output logic [OFF_W-1:0]      off
);
    // Pick the highest slot whose first bit is at or below pos.
    always_comb begin
        slot = '0;
        off  = OFF_W'(pos);
        for (int k = 1; k <= NUM_SLOTS; k++) begin
            if (int'(pos) >= TAG_W + SLOT_W * (k - 1)) begin
                slot = SLOT_IDX_W'(k);
                off  = OFF_W'(int'(pos) - TAG_W - SLOT_W * (k - 1));
            end
        end
    end
endmodule

// File: rtl/aclink_frame_counter.sv
// Module: aclink_frame_counter
// Free-running frame bit position counter and the SYNC marker.
// pos is the position of the bit currently on the serial output.
// SYNC rises as pos enters the last position of a frame, one cycle
// before the first tag bit, and stays high for TAG_W cycles.
// load_frame marks the edge at which the next frame's contents are
// taken. Assumes FRAME_BITS == 2**POS_W.
module aclink_frame_counter #(
    parameter int POS_W = aclink_pkg::POS_W,
    parameter int TAG_W = aclink_pkg::TAG_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] pos_nxt,
    output logic             sync,
    output logic             load_frame
);
    localparam logic [POS_W-1:0] LAST_POS  = '1;
    localparam logic [POS_W-1:0] RESET_POS = LAST_POS - POS_W'(1);

    // Next position, wrapping at the end of the frame.
    always_comb begin
        pos_nxt    = pos + POS_W'(1);
        load_frame = (pos_nxt == LAST_POS);
    end

    // Advance the position and register SYNC for the coming bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= RESET_POS;
            sync <= 1'b0;
        end else begin
            pos  <= pos_nxt;
            sync <= (pos_nxt == LAST_POS) || (int'(pos_nxt) < TAG_W - 1);
        end
    end
endmodule

// File: rtl/aclink_tx_builder.sv
// Module: aclink_tx_builder
// Holds offered playback and command pairs until the next frame
// boundary, copies them into a per-frame shadow, and serializes the
// tag and slot contents MSB first on the rising edge. An offer is used
// for exactly one frame; later offers before the boundary replace
// earlier ones. Assumes SAMPLE_W <= SLOT_W.
module aclink_tx_builder #(
    parameter int POS_W      = aclink_pkg::POS_W,
    parameter int TAG_W      = aclink_pkg::TAG_BITS,
    parameter int SLOT_W     = aclink_pkg::SLOT_BITS,
    parameter int NUM_SLOTS  = aclink_pkg::NUM_SLOTS,
    parameter int SAMPLE_W   = aclink_pkg::SAMPLE_BITS,
    parameter int SLOT_IDX_W = aclink_pkg::SLOT_IDX_W,
    parameter int OFF_W      = aclink_pkg::OFF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_frame,
    input  logic [POS_W-1:0]    pos_nxt,
    input  logic                play_valid,
    input  logic [SAMPLE_W-1:0] play_left,
    input  logic [SAMPLE_W-1:0] play_right,
    input  logic                cmd_valid,
    input  logic [SLOT_W-1:0]   cmd_addr,
    input  logic [SLOT_W-1:0]   cmd_data,
    output logic                sdata_out
);
    import aclink_pkg::*;

    logic                pl_pend, cm_pend;
    logic [SAMPLE_W-1:0] pl_l, pl_r;
    logic [SLOT_W-1:0]   cm_a, cm_d;
    logic                sh_pl_v, sh_cm_v;
    logic [SAMPLE_W-1:0] sh_l, sh_r;
    logic [SLOT_W-1:0]   sh_a, sh_d;
    logic [SLOT_W-1:0]   pcm_l_word, pcm_r_word, slot_word;
    logic [TAG_W-1:0]    tag_vec;
    logic [SLOT_IDX_W-1:0] slot_n;
    logic [OFF_W-1:0]    off_n;
    logic                bit_n;

    // Holding stage for playback offers between boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_pend <= 1'b0;
            pl_l    <= '0;
            pl_r    <= '0;
        end else if (load_frame) begin
            pl_pend <= 1'b0;
        end else if (play_valid) begin
            pl_pend <= 1'b1;
            pl_l    <= play_left;
            pl_r    <= play_right;
        end
    end

    // Holding stage for command offers between boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_pend <= 1'b0;
            cm_a    <= '0;
            cm_d    <= '0;
        end else if (load_frame) begin
            cm_pend <= 1'b0;
        end else if (cmd_valid) begin
            cm_pend <= 1'b1;
            cm_a    <= cmd_addr;
            cm_d    <= cmd_data;
        end
    end

    // Frame shadow, taken at the boundary; an offer in that same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pl_v <= 1'b0;
            sh_cm_v <= 1'b0;
            sh_l    <= '0;
            sh_r    <= '0;
            sh_a    <= '0;
            sh_d    <= '0;
        end else if (load_frame) begin
            sh_pl_v <= play_valid | pl_pend;
            sh_l    <= play_valid ? play_left  : pl_l;
            sh_r    <= play_valid ? play_right : pl_r;
            sh_cm_v <= cmd_valid | cm_pend;
            sh_a    <= cmd_valid ? cmd_addr : cm_a;
            sh_d    <= cmd_valid ? cmd_data : cm_d;
        end
    end

    // Sample placement: left-justified, low bits zero-filled.
    generate
        if (SLOT_W > SAMPLE_W) begin : g_pad
            assign pcm_l_word = {sh_l, {(SLOT_W - SAMPLE_W){1'b0}}};
            assign pcm_r_word = {sh_r, {(SLOT_W - SAMPLE_W){1'b0}}};
        end else begin : g_full
            assign pcm_l_word = sh_l;
            assign pcm_r_word = sh_r;
        end
    endgenerate

    // Tag word from the shadow flags.
    always_comb begin
        tag_vec               = '0;
        tag_vec[TAG_CMD_ADDR] = sh_cm_v;
        tag_vec[TAG_CMD_DATA] = sh_cm_v;
        tag_vec[TAG_PCM_L]    = sh_pl_v;
        tag_vec[TAG_PCM_R]    = sh_pl_v;
        tag_vec[TAG_FRAME_OK] = sh_cm_v | sh_pl_v;
    end

    aclink_slot_decode #(
        .POS_W(POS_W), .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
        .SLOT_IDX_W(SLOT_IDX_W), .OFF_W(OFF_W)
    ) u_dec (
        .pos  (pos_nxt),
        .slot (slot_n),
        .off  (off_n)
    );

    // Choose the word of the coming slot and the bit to send from it.
    always_comb begin
        slot_word = '0;
        if (sh_cm_v && slot_n == SLOT_IDX_W'(SLOT_CMD_ADDR)) slot_word = sh_a;
        if (sh_cm_v && slot_n == SLOT_IDX_W'(SLOT_CMD_DATA)) slot_word = sh_d;
        if (sh_pl_v && slot_n == SLOT_IDX_W'(SLOT_PCM_L))    slot_word = pcm_l_word;
        if (sh_pl_v && slot_n == SLOT_IDX_W'(SLOT_PCM_R))    slot_word = pcm_r_word;
        if (slot_n == '0) bit_n = tag_vec[TAG_W - 1 - int'(off_n)];
        else              bit_n = slot_word[SLOT_W - 1 - int'(off_n)];
    end

    // Serial output register, updated on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sdata_out <= 1'b0;
        else        sdata_out <= bit_n;
    end
endmodule

// File: rtl/aclink_rx_parser.sv
// Module: aclink_rx_parser
// Samples the codec's serial line on the falling edge together with the
// frame position, then on the rising edge shifts bits into a slot word
// and, at each slot end, captures the tag, the status pair and the
// record pair. Strobes depend on the flags of the frame's received tag.
// Assumes the codec frame is aligned to the controller's position count.
module aclink_rx_parser #(
    parameter int POS_W      = aclink_pkg::POS_W,
    parameter int TAG_W      = aclink_pkg::TAG_BITS,
    parameter int SLOT_W     = aclink_pkg::SLOT_BITS,
    parameter int NUM_SLOTS  = aclink_pkg::NUM_SLOTS,
    parameter int SAMPLE_W   = aclink_pkg::SAMPLE_BITS,
    parameter int SLOT_IDX_W = aclink_pkg::SLOT_IDX_W,
    parameter int OFF_W      = aclink_pkg::OFF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [POS_W-1:0]    pos,
    input  logic                sdata_in,
    output logic                rec_valid,
    output logic [SAMPLE_W-1:0] rec_left,
    output logic [SAMPLE_W-1:0] rec_right,
    output logic [TAG_W-1:0]    rec_tag,
    output logic                stat_valid,
    output logic [SLOT_W-1:0]   stat_addr,
    output logic [SLOT_W-1:0]   stat_data
);
    import aclink_pkg::*;

    logic                  rx_bit;
    logic [POS_W-1:0]      rx_pos;
    logic [SLOT_W-1:0]     shreg, word;
    logic [SLOT_W-1:0]     hold_a;
    logic [SAMPLE_W-1:0]   hold_l;
    logic [SLOT_IDX_W-1:0] rx_slot;
    logic [OFF_W-1:0]      rx_off;
    logic                  slot_end, tag_end;

    // Falling-edge capture of the serial bit and its frame position.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            rx_bit <= 1'b0;
            rx_pos <= POS_W'(FRAME_BITS - 2);
        end else begin
            rx_bit <= sdata_in;
            rx_pos <= pos;
        end
    end

    aclink_slot_decode #(
        .POS_W(POS_W), .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
        .SLOT_IDX_W(SLOT_IDX_W), .OFF_W(OFF_W)
    ) u_dec (
        .pos  (rx_pos),
        .slot (rx_slot),
        .off  (rx_off)
    );

    // Word including the newest bit, and slot-end markers.
    always_comb begin
        word     = {shreg[SLOT_W-2:0], rx_bit};
        tag_end  = (rx_slot == '0) && (int'(rx_off) == TAG_W - 1);
        slot_end = (rx_slot != '0) && (int'(rx_off) == SLOT_W - 1);
    end

    // Shift register for incoming bits.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= word;
    end

    // Tag capture at the end of the tag slot.
    always_ff @(posedge clk) begin
        if (!rst_n)       rec_tag <= '0;
        else if (tag_end) rec_tag <= word[TAG_W-1:0];
    end

    // Status pair: hold slot 1, present both at the end of slot 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_a     <= '0;
            stat_valid <= 1'b0;
            stat_addr  <= '0;
            stat_data  <= '0;
        end else begin
            stat_valid <= 1'b0;
            if (slot_end && rx_slot == SLOT_IDX_W'(SLOT_CMD_ADDR)) hold_a <= word;
            if (slot_end && rx_slot == SLOT_IDX_W'(SLOT_CMD_DATA)
                && rec_tag[TAG_FRAME_OK] && rec_tag[TAG_CMD_ADDR]) begin
                stat_valid <= 1'b1;
                stat_addr  <= hold_a;
                stat_data  <= word;
            end
        end
    end

    // Record pair: hold slot 3 sample, present both at the end of slot 4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l    <= '0;
            rec_valid <= 1'b0;
            rec_left  <= '0;
            rec_right <= '0;
        end else begin
            rec_valid <= 1'b0;
            if (slot_end && rx_slot == SLOT_IDX_W'(SLOT_PCM_L))
                hold_l <= word[SLOT_W-1 -: SAMPLE_W];
            if (slot_end && rx_slot == SLOT_IDX_W'(SLOT_PCM_R) && rec_tag[TAG_FRAME_OK]
                && rec_tag[TAG_PCM_L] && rec_tag[TAG_PCM_R]) begin
                rec_valid <= 1'b1;
                rec_left  <= hold_l;
                rec_right <= word[SLOT_W-1 -: SAMPLE_W];
            end
        end
    end
endmodule

// File: rtl/aclink_frame_engine.sv
// Module: aclink_frame_engine
// Controller side of an AC97-style serial audio link: generates SYNC and
// the outgoing 256-bit frame, and parses the incoming frame. Runs from
// the codec's bit clock only; reset is synchronous and active low.
module aclink_frame_engine #(
    parameter int SAMPLE_W = aclink_pkg::SAMPLE_BITS,
    parameter int SLOT_W   = aclink_pkg::SLOT_BITS,
    parameter int TAG_W    = aclink_pkg::TAG_BITS
) (
    input  logic                bit_clk,
    input  logic                rst_n,
    output logic                sync,
    output logic                sdata_out,
    input  logic                sdata_in,
    input  logic                play_valid,
    input  logic [SAMPLE_W-1:0] play_left,
    input  logic [SAMPLE_W-1:0] play_right,
    input  logic                cmd_valid,
    input  logic [SLOT_W-1:0]   cmd_addr,
    input  logic [SLOT_W-1:0]   cmd_data,
    output logic                rec_valid,
    output logic [SAMPLE_W-1:0] rec_left,
    output logic [SAMPLE_W-1:0] rec_right,
    output logic [TAG_W-1:0]    rec_tag,
    output logic                stat_valid,
    output logic [SLOT_W-1:0]   stat_addr,
    output logic [SLOT_W-1:0]   stat_data
);
    localparam int POS_W = aclink_pkg::POS_W;

    logic [POS_W-1:0] pos, pos_nxt;
    logic             load_frame;

    aclink_frame_counter #(.POS_W(POS_W), .TAG_W(TAG_W)) u_cnt (
        .clk        (bit_clk),
        .rst_n      (rst_n),
        .pos        (pos),
        .pos_nxt    (pos_nxt),
        .sync       (sync),
        .load_frame (load_frame)
    );

    aclink_tx_builder #(
        .POS_W(POS_W), .TAG_W(TAG_W), .SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)
    ) u_tx (
        .clk        (bit_clk),
        .rst_n      (rst_n),
        .load_frame (load_frame),
        .pos_nxt    (pos_nxt),
        .play_valid (play_valid),
        .play_left  (play_left),
        .play_right (play_right),
        .cmd_valid  (cmd_valid),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .sdata_out  (sdata_out)
    );

    aclink_rx_parser #(
        .POS_W(POS_W), .TAG_W(TAG_W), .SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W)
    ) u_rx (
        .clk        (bit_clk),
        .rst_n      (rst_n),
        .pos        (pos),
        .sdata_in   (sdata_in),
        .rec_valid  (rec_valid),
        .rec_left   (rec_left),
        .rec_right  (rec_right),
        .rec_tag    (rec_tag),
        .stat_valid (stat_valid),
        .stat_addr  (stat_addr),
        .stat_data  (stat_data)
    );
endmodule

// File: rtl/aclink_checker.sv
// Module: aclink_checker
// Port-level protocol checks for aclink_frame_engine, bound to it below.
// Tracks its own frame position from SYNC rises, independent of the RTL.
module aclink_checker (
    input logic clk,
    input logic rst_n,
    input logic sync,
    input logic sdata_out,
    input logic rec_valid,
    input logic stat_valid
);
    import aclink_pkg::*;

    localparam int CW       = POS_W + 1;
    localparam int PAD_L0   = slot_first_pos(SLOT_PCM_L) + SAMPLE_BITS;
    localparam int PAD_R0   = slot_first_pos(SLOT_PCM_R) + SAMPLE_BITS;
    localparam int PAD_N    = SLOT_BITS - SAMPLE_BITS;
    localparam int IDLE_LO  = slot_first_pos(SLOT_PCM_R + 1);

    logic [CW-1:0] since;
    logic [CW-1:0] hi_cnt;
    logic          seen;
    logic          sync_d;
    logic          in_pad, in_idle;

    // Position tracker: cycles since the last SYNC rise, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since  <= '0;
            hi_cnt <= '0;
            seen   <= 1'b0;
            sync_d <= 1'b0;
        end else begin
            sync_d <= sync;
            if (sync && !sync_d) begin
                since <= '0;
                seen  <= 1'b1;
            end else if (since != '1) begin
                since <= since + CW'(1);
            end
            hi_cnt <= sync ? hi_cnt + CW'(1) : '0;
        end
    end

    // Position windows for pad bits and idle slots.
    always_comb begin
        in_pad  = ((int'(since) >= PAD_L0) && (int'(since) < PAD_L0 + PAD_N))
               || ((int'(since) >= PAD_R0) && (int'(since) < PAD_R0 + PAD_N));
        in_idle = (int'(since) >= IDLE_LO) && (int'(since) < FRAME_BITS);
    end

    AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && sync && !sync_d) |-> (int'(since) == FRAME_BITS - 1)); // R1

    AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && sync_d) |-> (int'(hi_cnt) == TAG_BITS)); // R2

    AST_PCM_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && in_pad) |-> !sdata_out); // R4

    AST_IDLE_SLOTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && in_idle) |-> !sdata_out); // R7

    AST_REC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid); // R9

    AST_STAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid); // R10

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sdata_out && !rec_valid && !stat_valid)); // R11
endmodule

bind aclink_frame_engine aclink_checker u_chk (
    .clk        (bit_clk),
    .rst_n      (rst_n),
    .sync       (sync),
    .sdata_out  (sdata_out),
    .rec_valid  (rec_valid),
    .stat_valid (stat_valid)
);

// File: tb/sim_aclink_frame_engine.sv
// Bench for aclink_frame_engine: a vector table of outgoing offers and
// incoming codec frames walked by one loop, then directed tests.
module sim_aclink_frame_engine;
    localparam int CLK_PERIOD = 82;
    localparam int NV         = 6;
    localparam int WATCHDOG   = 100000;

    // vector table: playback offer, command offer, codec frame contents
    localparam logic        V_PV [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [17:0] V_PL [NV] = '{18'h2A5C3, 18'h00000, 18'h3FFFF, 18'h00000, 18'h00000, 18'h1C71C};
    localparam logic [17:0] V_PR [NV] = '{18'h15A3C, 18'h00000, 18'h00001, 18'h00000, 18'h3FFFF, 18'h2B2B2};
    localparam logic        V_CV [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic [19:0] V_CA [NV] = '{20'h0, 20'h80260, 20'h12345, 20'h0, 20'h0, 20'h0};
    localparam logic [19:0] V_CD [NV] = '{20'h0, 20'h0F0F0, 20'hABCDE, 20'h0, 20'h0, 20'h0};
    localparam logic [15:0] V_CT [NV] = '{16'h9800, 16'hE000, 16'hF800, 16'h1800, 16'h9000, 16'h8800};
    localparam logic [19:0] V_RL [NV] = '{20'hFEDCB, 20'h11111, 20'h3C3C3, 20'hFFFFF, 20'h6789A, 20'h0000F};
    localparam logic [19:0] V_RR [NV] = '{20'h12345, 20'h22222, 20'hC3C3D, 20'hFFFFF, 20'h98765, 20'hF0000};

    logic        bit_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdata_in = 1'b0;
    logic        play_valid = 1'b0, cmd_valid = 1'b0;
    logic [17:0] play_left = '0, play_right = '0;
    logic [19:0] cmd_addr = '0, cmd_data = '0;
    logic        sync, sdata_out, rec_valid, stat_valid;
    logic [17:0] rec_left, rec_right;
    logic [15:0] rec_tag;
    logic [19:0] stat_addr, stat_data;

    always #(CLK_PERIOD / 2) bit_clk = ~bit_clk;

    aclink_frame_engine u0 (
        .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .sdata_out(sdata_out),
        .sdata_in(sdata_in), .play_valid(play_valid), .play_left(play_left),
        .play_right(play_right), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rec_valid(rec_valid), .rec_left(rec_left),
        .rec_right(rec_right), .rec_tag(rec_tag), .stat_valid(stat_valid),
        .stat_addr(stat_addr), .stat_data(stat_data)
    );

    int n_chk = 0, n_bad = 0;
    logic [255:0] cap;
    int sync_hi, rec_n, rec_at, st_n, st_at;
    logic end_sync;
    logic [17:0] got_l, got_r;
    logic [19:0] got_a, got_d;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_frame(input logic [15:0] t, input logic [19:0] s1,
            input logic [19:0] s2, input logic [19:0] s3, input logic [19:0] s4, input logic [19:0] fill);
        logic [255:0] f;
        f = '0;
        f[255:240] = t;
        f[239:220] = s1;
        f[219:200] = s2;
        f[199:180] = s3;
        f[179:160] = s4;
        for (int k = 5; k <= 12; k++) f[239 - 20 * (k - 1) -: 20] = fill;
        return f;
    endfunction

    function automatic logic [19:0] slot_of(input logic [255:0] f, input int k);
        return f[239 - 20 * (k - 1) -: 20];
    endfunction

    // Wait at falling edges until SYNC is first seen high (position 255).
    task automatic wait_sync();
        logic prev;
        prev = 1'b1;
        while (1) begin
            @(negedge bit_clk);
            if (sync && !prev) break;
            prev = sync;
        end
    endtask

    // Capture one whole frame while acting as the codec.
    task automatic run_frame(input logic [255:0] cf);
        wait_sync();
        sync_hi = 0; rec_n = 0; rec_at = -1; st_n = 0; st_at = -1;
        for (int b = 0; b < 256; b++) begin
            @(posedge bit_clk);
            sdata_in <= cf[255 - b];
            @(negedge bit_clk);
            cap[255 - b] = sdata_out;
            if (sync) sync_hi++;
            if (rec_valid) begin rec_n++; rec_at = b; got_l = rec_left; got_r = rec_right; end
            if (stat_valid) begin st_n++; st_at = b; got_a = stat_addr; got_d = stat_data; end
        end
        end_sync = sync;
    endtask

    function automatic logic [15:0] exp_tag(input logic pv, input logic cv);
        logic [15:0] t;
        t = '0;
        t[12] = pv; t[11] = pv; t[14] = cv; t[13] = cv;
        t[15] = pv | cv;
        return t;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [255:0] ef, cf;
        logic         rx_ok, st_ok;

        // R11: quiet during reset, SYNC on the first edge after release
        repeat (4) @(negedge bit_clk);
        chk(!sync && !sdata_out, "R11 reset sync/sdata", {30'b0, sync, sdata_out}, 0);
        chk(!rec_valid && !stat_valid, "R11 reset strobes", {30'b0, rec_valid, stat_valid}, 0);
        rst_n = 1'b1;
        @(negedge bit_clk);
        chk(sync == 1'b1, "R11 first sync rise", {31'b0, sync}, 1);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            wait_sync();
            play_valid = V_PV[i]; play_left = V_PL[i]; play_right = V_PR[i];
            cmd_valid = V_CV[i]; cmd_addr = V_CA[i]; cmd_data = V_CD[i];
            @(negedge bit_clk);
            play_valid = 1'b0; cmd_valid = 1'b0;
            ef = mk_frame(exp_tag(V_PV[i], V_CV[i]),
                          V_CV[i] ? V_CA[i] : 20'h0, V_CV[i] ? V_CD[i] : 20'h0,
                          V_PV[i] ? {V_PL[i], 2'b00} : 20'h0, V_PV[i] ? {V_PR[i], 2'b00} : 20'h0, 20'h0);
            cf = mk_frame(V_CT[i], 20'hC0DE0 + 20'(i), 20'h5A5A5 ^ 20'(i), V_RL[i], V_RR[i], 20'hA5A5A);
            run_frame(cf);
            chk(end_sync == 1'b1, "R1 next frame at 256", {31'b0, end_sync}, 1);
            chk(sync_hi == 16, "R2 sync high cycles", sync_hi, 16);
            chk(cap[255:240] == ef[255:240], "R3 tag", {16'b0, cap[255:240]}, {16'b0, ef[255:240]});
            chk(slot_of(cap, 1) == slot_of(ef, 1), "R6 slot1", {12'b0, slot_of(cap, 1)}, {12'b0, slot_of(ef, 1)});
            chk(slot_of(cap, 2) == slot_of(ef, 2), "R6 slot2", {12'b0, slot_of(cap, 2)}, {12'b0, slot_of(ef, 2)});
            chk(slot_of(cap, 3) == slot_of(ef, 3), "R4 slot3", {12'b0, slot_of(cap, 3)}, {12'b0, slot_of(ef, 3)});
            chk(slot_of(cap, 4) == slot_of(ef, 4), "R4 slot4", {12'b0, slot_of(cap, 4)}, {12'b0, slot_of(ef, 4)});
            chk(cap[159:0] == '0, "R7 idle slots", {31'b0, |cap[159:0]}, 0);
            chk(rec_tag == V_CT[i], "R8 rec_tag", {16'b0, rec_tag}, {16'b0, V_CT[i]});
            rx_ok = V_CT[i][15] & V_CT[i][12] & V_CT[i][11];
            chk(rec_n == (rx_ok ? 1 : 0), "R9 rec strobe count", rec_n, rx_ok ? 1 : 0);
            if (rx_ok) begin
                chk(rec_at == 96, "R9 rec position", rec_at, 96);
                chk(got_l == V_RL[i][19:2], "R8 R9 rec_left", {14'b0, got_l}, {14'b0, V_RL[i][19:2]});
                chk(got_r == V_RR[i][19:2], "R8 R9 rec_right", {14'b0, got_r}, {14'b0, V_RR[i][19:2]});
            end
            st_ok = V_CT[i][15] & V_CT[i][14];
            chk(st_n == (st_ok ? 1 : 0), "R10 stat strobe count", st_n, st_ok ? 1 : 0);
            if (st_ok) begin
                chk(st_at == 56, "R10 stat position", st_at, 56);
                chk(got_a == 20'hC0DE0 + 20'(i), "R10 stat_addr", {12'b0, got_a}, {12'b0, 20'hC0DE0 + 20'(i)});
                chk(got_d == (20'h5A5A5 ^ 20'(i)), "R10 stat_data", {12'b0, got_d}, {12'b0, 20'h5A5A5 ^ 20'(i)});
            end
        end

        // R5: two offers before one boundary, the later one is sent
        wait_sync();
        play_valid = 1'b1; play_left = 18'h11111; play_right = 18'h22222;
        @(negedge bit_clk);
        play_left = 18'h3ABCD; play_right = 18'h05432;
        @(negedge bit_clk);
        play_valid = 1'b0;
        run_frame('0);
        chk(slot_of(cap, 3) == {18'h3ABCD, 2'b00}, "R5 last left wins", {12'b0, slot_of(cap, 3)}, {12'b0, 18'h3ABCD, 2'b00});
        chk(slot_of(cap, 4) == {18'h05432, 2'b00}, "R5 last right wins", {12'b0, slot_of(cap, 4)}, {12'b0, 18'h05432, 2'b00});

        // R4: the pair is sent once; the following frame is empty
        run_frame('0);
        chk(cap[255:240] == 16'h0, "R4 R3 tag clear after use", {16'b0, cap[255:240]}, 0);
        chk(cap == '0, "R4 empty frame", {31'b0, |cap}, 0);
        chk(end_sync == 1'b1 && sync_hi == 16, "R1 R2 steady framing", sync_hi, 16);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule